// File: doc/BRIEF.md
# QoS Region Classifier with Timeout

This block sorts one incoming read or write request into a priority region according to its 4-bit QoS value and a set of programmable split levels. Each region has a traffic class assigned to it and a timeout to go with it. When the request is accepted, the block captures the region and its class, and it loads an 11-bit aging counter with the timeout chosen for that region. A free-running tick then counts the counter down. When a request of the variable-priority class has aged to zero, the block raises an expiry flag, which a downstream arbiter can use to promote that request.

One instance serves one port in one direction and tracks one request at a time. A new acceptance replaces the request being tracked. The `IS_WRITE` parameter picks the direction. The read variant has a single split level, which gives two regions, and reads their class as low (0), variable (1) or high (2) priority. The write variant has two split levels, which give three regions, and reads their class as normal (0) or variable (1) priority. Settings that make no sense are reported on a registered configuration-error flag. Queue storage and the bus handshake live outside this block.

Top module: `qos_region_classifier`

## Requirements
- R1: A request accepted with a QoS value less than or equal to `cfgLevelLo` is placed in region 0, reported on `regionOut` as 0 from the cycle after acceptance.
- R2: In the read variant, a QoS value above `cfgLevelLo` is placed in region 1 (`regionOut` = 1). The read variant never reports region 2.
- R3: In the write variant, a QoS value above `cfgLevelLo` and no higher than `cfgLevelHi` is placed in region 1. A QoS value above `cfgLevelHi` is placed in region 2 (`regionOut` = 2).
- R4: On acceptance, `classOut` takes the class field of the chosen region: `cfgClass0`, `cfgClass1` or `cfgClass2` for regions 0, 1 and 2. It holds that value until the next acceptance. Class code 1 means variable priority in both directions.
- R5: The timeout loaded depends on the region. For reads, region 0 uses `cfgTimeoutA` and region 1 uses `cfgTimeoutB`. For writes, regions 0 and 1 share `cfgTimeoutA` and region 2 uses `cfgTimeoutB`.
- R6: The counter loads on the clock edge where `qosValid` is high, and an acceptance wins over a tick in the same cycle. After that, each tick seen while `trackValid` is high lowers the counter by one, and the counter stays at zero once it gets there. `trackValid` rises on the first acceptance.
- R7: `expired` is high exactly when a request is tracked, its class is 1, and its counter is zero. It stays low for any other class.
- R8: In the read variant, `cfgError` goes high one cycle after `cfgLevelLo` equals 15 or either `cfgClass0` or `cfgClass1` equals 3.
- R9: In the write variant, `cfgError` goes high one cycle after any of these holds: `cfgLevelHi` is not greater than `cfgLevelLo`, `cfgLevelHi` equals 15, or any of the three class fields is above 1. When `cfgLevelHi` is not greater than `cfgLevelLo`, region 2 is empty, so any QoS value above `cfgLevelLo` maps to region 1.
- R10: While reset is held, `trackValid`, `regionOut`, `classOut`, `expired` and `cfgError` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qosIn | input | QOS_W | QoS value of the request being accepted |
| qosValid | input | 1 | Accept strobe, one request per high cycle |
| tick | input | 1 | Aging tick, one counter step per high cycle |
| cfgLevelLo | input | QOS_W | Upper bound of region 0 |
| cfgLevelHi | input | QOS_W | Upper bound of region 1 (write variant only) |
| cfgClass0 | input | CLS_W | Class of region 0 |
| cfgClass1 | input | CLS_W | Class of region 1 |
| cfgClass2 | input | CLS_W | Class of region 2 (write variant only) |
| cfgTimeoutA | input | TO_W | Timeout of read region 0, or of write regions 0 and 1 |
| cfgTimeoutB | input | TO_W | Timeout of read region 1, or of write region 2 |
| trackValid | output | 1 | A request is being tracked |
| regionOut | output | 2 | Region of the tracked request |
| classOut | output | CLS_W | Class of the tracked request |
| expired | output | 1 | Variable-priority request has aged out |
| cfgError | output | 1 | Registered configuration error |

## Verification
A read instance and a write instance are driven with the same stimulus. Because the timeout a request loads depends on the direction, the same request expires after a different number of ticks in each instance, and this shows whether the timeout is picked per region. Directed sequences cover the following cases:
- QoS values that land on either side of each split level, which show the comparison is inclusive;
- an acceptance in the same cycle as a tick, which shows that the load wins;
- equal write levels, which show region 2 collapsing into region 1;
- an illegal read class, which shows the error flag.

A long stretch of random levels, classes, small timeouts and sparse acceptances then checks that re-acceptance replaces the tracked request and that the counter holds at zero.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

  typedef enum logic [1:0] {
    REGION0 = 2'd0,
    REGION1 = 2'd1,
    REGION2 = 2'd2
  } region_e;

  // Strobes from control into the datapath
  typedef struct packed {
    logic load;
    logic dec;
  } qrc_strobe_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic cntZero;
    logic isVar;
  } qrc_status_t;

  localparam int unsigned VAR_CLASS   = 1;
  localparam int unsigned RD_CLS_MAX  = 2;
  localparam int unsigned WR_CLS_MAX  = 1;

endpackage

// File: rtl/qrc_region_decode.sv
module qrc_region_decode
  import qrc_pkg::*;
#(
  parameter int unsigned QOS_W    = 4,
  parameter int unsigned CLS_W    = 2,
  parameter bit          IS_WRITE = 1'b0
) (
  input  logic [QOS_W-1:0] qos,
  input  logic [QOS_W-1:0] levelLo,
  input  logic [QOS_W-1:0] levelHi,
  input  logic [CLS_W-1:0] cls0,
  input  logic [CLS_W-1:0] cls1,
  input  logic [CLS_W-1:0] cls2,
  output region_e          region,
  output logic             cfgBad
);

  localparam logic [QOS_W-1:0] QOS_TOP = {QOS_W{1'b1}};
  localparam logic [CLS_W-1:0] RD_MAX  = CLS_W'(RD_CLS_MAX);
  localparam logic [CLS_W-1:0] WR_MAX  = CLS_W'(WR_CLS_MAX);

  logic inLow;
  assign inLow = (qos <= levelLo);

  generate
    if (IS_WRITE) begin : g_write
      logic levelsBad;
      logic classBad;
      logic upperUsable;
      assign levelsBad   = (levelHi <= levelLo) || (levelHi == QOS_TOP);
      assign classBad    = (cls0 > WR_MAX) || (cls1 > WR_MAX) || (cls2 > WR_MAX);
      assign upperUsable = (levelHi > levelLo);
      always_comb begin
        if (inLow)                          region = REGION0;
        else if (upperUsable && qos > levelHi) region = REGION2;
        else                                region = REGION1;
      end
      assign cfgBad = levelsBad || classBad;
    end else begin : g_read
      logic levelBad;
      logic classBad;
      assign levelBad = (levelLo == QOS_TOP);
      assign classBad = (cls0 > RD_MAX) || (cls1 > RD_MAX);
      always_comb region = inLow ? REGION0 : REGION1;
      assign cfgBad = levelBad || classBad;
    end
  endgenerate

endmodule

// File: rtl/qrc_control.sv
module qrc_control
  import qrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accept,
  input  logic        tick,
  input  logic        cfgBadIn,
  input  qrc_status_t status,
  output qrc_strobe_t strb,
  output logic        active,
  output logic        expired,
  output logic        cfgError
);

  logic activeQ;
  logic cfgErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cfgErrQ <= 1'b0;
    end else begin
      activeQ <= activeQ | accept;
      cfgErrQ <= cfgBadIn;
    end
  end

  always_comb begin
    strb.load = accept;
    strb.dec  = tick && activeQ && !accept;
  end

  assign active   = activeQ;
  assign expired  = activeQ && status.isVar && status.cntZero;
  assign cfgError = cfgErrQ;

  assert_accept_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> activeQ);

  assert_error_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgBadIn |=> cfgError);

endmodule

// File: rtl/qrc_datapath.sv
module qrc_datapath
  import qrc_pkg::*;
#(
  parameter int unsigned TO_W     = 11,
  parameter int unsigned CLS_W    = 2,
  parameter bit          IS_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  qrc_strobe_t      strb,
  input  region_e          regionIn,
  input  logic [CLS_W-1:0] cls0,
  input  logic [CLS_W-1:0] cls1,
  input  logic [CLS_W-1:0] cls2,
  input  logic [TO_W-1:0]  toA,
  input  logic [TO_W-1:0]  toB,
  output region_e          regionQ,
  output logic [CLS_W-1:0] classQ,
  output qrc_status_t      status
);

  localparam logic [CLS_W-1:0] VAR_CODE = CLS_W'(VAR_CLASS);

  logic [CLS_W-1:0] clsSel;
  logic [TO_W-1:0]  toSel;
  logic [TO_W-1:0]  cntQ;

  generate
    if (IS_WRITE) begin : g_wsel
      always_comb begin
        unique case (regionIn)
          REGION0: clsSel = cls0;
          REGION1: clsSel = cls1;
          default: clsSel = cls2;
        endcase
        toSel = (regionIn == REGION2) ? toB : toA;
      end
    end else begin : g_rsel
      always_comb begin
        clsSel = (regionIn == REGION0) ? cls0 : cls1;
        toSel  = (regionIn == REGION0) ? toA : toB;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionQ <= REGION0;
      classQ  <= '0;
      cntQ    <= '0;
    end else if (strb.load) begin
      regionQ <= regionIn;
      classQ  <= clsSel;
      cntQ    <= toSel;
    end else if (strb.dec && cntQ != '0) begin
      cntQ    <= cntQ - 1'b1;
    end
  end

  assign status.cntZero = (cntQ == '0);
  assign status.isVar   = (classQ == VAR_CODE);

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cntQ == $past(toSel));

  assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.load && cntQ != '0) |=> cntQ == $past(cntQ) - 1'b1);

  assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && cntQ == '0) |=> cntQ == '0);

endmodule

// File: rtl/qos_region_classifier.sv
module qos_region_classifier
  import qrc_pkg::*;
#(
  parameter int unsigned QOS_W    = 4,
  parameter int unsigned TO_W     = 11,
  parameter int unsigned CLS_W    = 2,
  parameter bit          IS_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [QOS_W-1:0] qosIn,
  input  logic             qosValid,
  input  logic             tick,
  input  logic [QOS_W-1:0] cfgLevelLo,
  input  logic [QOS_W-1:0] cfgLevelHi,
  input  logic [CLS_W-1:0] cfgClass0,
  input  logic [CLS_W-1:0] cfgClass1,
  input  logic [CLS_W-1:0] cfgClass2,
  input  logic [TO_W-1:0]  cfgTimeoutA,
  input  logic [TO_W-1:0]  cfgTimeoutB,
  output logic             trackValid,
  output logic [1:0]       regionOut,
  output logic [CLS_W-1:0] classOut,
  output logic             expired,
  output logic             cfgError
);

  region_e     regionNext;
  region_e     regionQ;
  logic        cfgBad;
  qrc_strobe_t strb;
  qrc_status_t status;

  qrc_region_decode #(.QOS_W(QOS_W), .CLS_W(CLS_W), .IS_WRITE(IS_WRITE)) i_decode (
    .qos(qosIn), .levelLo(cfgLevelLo), .levelHi(cfgLevelHi),
    .cls0(cfgClass0), .cls1(cfgClass1), .cls2(cfgClass2),
    .region(regionNext), .cfgBad(cfgBad)
  );

  qrc_control i_control (
    .clk(clk), .rstN(rstN), .accept(qosValid), .tick(tick),
    .cfgBadIn(cfgBad), .status(status), .strb(strb),
    .active(trackValid), .expired(expired), .cfgError(cfgError)
  );

  qrc_datapath #(.TO_W(TO_W), .CLS_W(CLS_W), .IS_WRITE(IS_WRITE)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .regionIn(regionNext),
    .cls0(cfgClass0), .cls1(cfgClass1), .cls2(cfgClass2),
    .toA(cfgTimeoutA), .toB(cfgTimeoutB),
    .regionQ(regionQ), .classQ(classOut), .status(status)
  );

  assign regionOut = regionQ;

  assert_low_region_R1: assert property (@(posedge clk) disable iff (!rstN)
    (qosValid && qosIn <= cfgLevelLo) |=> regionOut == 2'd0);

  assert_expire_var_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    expired |-> (classOut == CLS_W'(VAR_CLASS) && trackValid));

  generate
    if (IS_WRITE) begin : g_wchk
      assert_upper_region_R3: assert property (@(posedge clk) disable iff (!rstN)
        (qosValid && cfgLevelHi > cfgLevelLo && qosIn > cfgLevelHi) |=> regionOut == 2'd2);
    end else begin : g_rchk
      assert_two_regions_R2: assert property (@(posedge clk) disable iff (!rstN)
        regionOut != 2'd2);
    end
  endgenerate

endmodule

// File: tb/test_qos_region_classifier.sv
module test_qos_region_classifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  qosIn = '0;
  logic        qosValid = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  lvlLo = 4'd7;
  logic [3:0]  lvlHi = 4'd12;
  logic [1:0]  cls0 = '0, cls1 = '0, cls2 = '0;
  logic [10:0] toA = '0, toB = '0;

  logic        tv [2];
  logic [1:0]  rg [2];
  logic [1:0]  cl [2];
  logic        ex [2];
  logic        ce [2];

  int checks = 0;
  int fails  = 0;

  // reference state, index 0 = read, 1 = write
  int mAct [2];
  int mReg [2];
  int mCls [2];
  int mCnt [2];
  int mErr [2];

  always #10 clk = ~clk;

  qos_region_classifier #(.IS_WRITE(1'b0)) i_qos_region_classifier (
    .clk(clk), .rstN(rstN), .qosIn(qosIn), .qosValid(qosValid), .tick(tick),
    .cfgLevelLo(lvlLo), .cfgLevelHi(lvlHi), .cfgClass0(cls0), .cfgClass1(cls1),
    .cfgClass2(cls2), .cfgTimeoutA(toA), .cfgTimeoutB(toB),
    .trackValid(tv[0]), .regionOut(rg[0]), .classOut(cl[0]), .expired(ex[0]), .cfgError(ce[0]));

  qos_region_classifier #(.IS_WRITE(1'b1)) i_qos_region_classifier_wr (
    .clk(clk), .rstN(rstN), .qosIn(qosIn), .qosValid(qosValid), .tick(tick),
    .cfgLevelLo(lvlLo), .cfgLevelHi(lvlHi), .cfgClass0(cls0), .cfgClass1(cls1),
    .cfgClass2(cls2), .cfgTimeoutA(toA), .cfgTimeoutB(toB),
    .trackValid(tv[1]), .regionOut(rg[1]), .classOut(cl[1]), .expired(ex[1]), .cfgError(ce[1]));

  function automatic int regionOf(int w, int q, int lo, int hi);
    if (q <= lo) return 0;
    if (w == 0) return 1;
    if (hi > lo && q > hi) return 2;
    return 1;
  endfunction

  function automatic int errOf(int w);
    if (w == 0) return (lvlLo == 15 || cls0 == 3 || cls1 == 3) ? 1 : 0;
    return (lvlHi <= lvlLo || lvlHi == 15 || cls0 > 1 || cls1 > 1 || cls2 > 1) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    for (int w = 0; w < 2; w++) begin
      if (!rstN) begin
        mAct[w] = 0; mReg[w] = 0; mCls[w] = 0; mCnt[w] = 0; mErr[w] = 0;
      end else begin
        mErr[w] = errOf(w);
        if (qosValid) begin
          int r;
          r = regionOf(w, int'(qosIn), int'(lvlLo), int'(lvlHi));
          mReg[w] = r;
          mCls[w] = (r == 0) ? int'(cls0) : (r == 1) ? int'(cls1) : int'(cls2);
          if (w == 0) mCnt[w] = (r == 0) ? int'(toA) : int'(toB);
          else        mCnt[w] = (r == 2) ? int'(toB) : int'(toA);
          mAct[w] = 1;
        end else if (tick && mAct[w] == 1 && mCnt[w] > 0) begin
          mCnt[w] = mCnt[w] - 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      for (int w = 0; w < 2; w++) begin
        string d;
        d = (w == 0) ? "rd" : "wr";
        chk({d, (mReg[w] == 0) ? " R1 region" : (w == 0) ? " R2 region" : " R3 region"},
            int'(rg[w]), mReg[w]);
        chk({d, " R4 class"}, int'(cl[w]), mCls[w]);
        chk({d, " R6 trackValid"}, int'(tv[w]), mAct[w]);
        chk({d, " R7 expired"}, int'(ex[w]),
            (mAct[w] == 1 && mCls[w] == 1 && mCnt[w] == 0) ? 1 : 0);
        chk({d, (w == 0) ? " R8 cfgError" : " R9 cfgError"}, int'(ce[w]), mErr[w]);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      chk("R10 reset trackValid", int'(tv[w]), 0);
      chk("R10 reset region", int'(rg[w]), 0);
      chk("R10 reset class", int'(cl[w]), 0);
      chk("R10 reset expired", int'(ex[w]), 0);
      chk("R10 reset cfgError", int'(ce[w]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R5: qos 9, lo 7, hi 12 -> read region1 (toB=5), write region1 (toA=2)
    lvlLo = 4'd7; lvlHi = 4'd12; cls0 = 2'd1; cls1 = 2'd1; cls2 = 2'd0;
    toA = 11'd2; toB = 11'd5;
    qosIn = 4'd9; qosValid = 1'b1; tick = 1'b0;
    @(negedge clk);
    qosValid = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 wr expiry after toA ticks", int'(ex[1]), 1);
    repeat (2) @(negedge clk);
    chk("R5 rd not yet expired", int'(ex[0]), 0);
    @(negedge clk);
    chk("R5 rd expiry after toB ticks", int'(ex[0]), 1);

    // R6: accept with tick in same cycle loads full value
    toA = 11'd3; qosIn = 4'd7; qosValid = 1'b1; tick = 1'b1;
    @(negedge clk);
    chk("R1 boundary qos==levelLo", int'(rg[0]), 0);
    qosValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 load beats tick", int'(ex[0]), 0);
    @(negedge clk);
    chk("R6 expiry after load", int'(ex[0]), 1);
    tick = 1'b0;

    // R3: write region2 with class 0 never expires (R7)
    qosIn = 4'd13; qosValid = 1'b1; cls2 = 2'd0; toB = 11'd0;
    @(negedge clk);
    qosValid = 1'b0;
    chk("R3 region2", int'(rg[1]), 2);
    chk("R7 class0 no expiry", int'(ex[1]), 0);

    // R9: equal levels collapse region2
    lvlLo = 4'd10; lvlHi = 4'd10; qosIn = 4'd14; qosValid = 1'b1;
    @(negedge clk);
    qosValid = 1'b0;
    chk("R9 empty region2", int'(rg[1]), 1);
    chk("R9 equal levels error", int'(ce[1]), 1);
    chk("R8 read unaffected", int'(ce[0]), 0);

    // R8: illegal read class
    lvlHi = 4'd12; cls1 = 2'd3;
    @(negedge clk);
    chk("R8 class 3 error", int'(ce[0]), 1);
    chk("R9 class 3 error", int'(ce[1]), 1);
    cls1 = 2'd1;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 31) == 0) begin
        lvlLo = 4'($urandom_range(0, 15));
        lvlHi = 4'($urandom_range(0, 15));
        cls0  = 2'($urandom_range(0, 3));
        cls1  = 2'($urandom_range(0, 3));
        cls2  = 2'($urandom_range(0, 3));
        toA   = 11'($urandom_range(0, 12));
        toB   = 11'($urandom_range(0, 12));
        if ($urandom_range(0, 7) == 0) toB = 11'd2047;
      end
      qosIn    = 4'($urandom_range(0, 15));
      qosValid = ($urandom_range(0, 9) == 0);
      tick     = ($urandom_range(0, 1) == 1);
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule